// File: doc/BRIEF.md
# Page Parity Swap Fixup Engine

This engine keeps a one-bit-per-page record of address bit 17 for a buffer built from 4 KiB pages, and restores page contents after the pages have been moved to new physical frames. A save walk takes the current physical address of each page from an input stream and stores its bit 17 in a small bitmap. A later fixup walk takes the new physical addresses and compares each page's bit 17 with the stored value. When the two differ, the engine rewrites that page in place over a 64-bit memory port. In every 128-byte block of the page, the lower 64-byte half and the upper 64-byte half trade places. The engine then raises that page's dirty flag.

A command names the walk type and the buffer size in bytes. The engine derives the page count from the size. Page addresses arrive one per valid/ready handshake, in page order. A busy flag covers the whole walk. A one-cycle done pulse marks its end. During the swap, one 64-byte half of the current block is held in local registers while the other half is copied over it.

Top module: `pg17_fixup_engine`

## Requirements
- R1: A save walk stores bit 17 of the address accepted for page i into bitmap entry i. A completed save walk marks the bitmap as present.
- R2: The page count of a walk is cmd_bytes divided by 4096, rounded down and limited to MAX_PAGES. A command that yields zero pages is ignored.
- R3: In a fixup walk, page i is rewritten only when bit 17 of its new address differs from bitmap entry i. A fixup walk leaves the bitmap unchanged.
- R4: A rewritten page has, for every 128-byte block, bytes 0–63 exchanged with bytes 64–127, across all 4096 bytes. The memory byte address is the page frame (address bits 31:12) followed by the 12-bit byte offset, and a beat is the 8 bytes at an 8-byte aligned address.
- R5: dirty bit i is 1 exactly when page i was rewritten by the most recent walk. All dirty bits clear when a walk is accepted.
- R6: A fixup command issued while no completed save walk exists is ignored: busy, done and pg_ready stay low.
- R7: busy is high from the cycle after a command is accepted until the last page is finished. done is high for exactly one cycle, in the first cycle with busy low after the walk.
- R8: A command presented while busy is high has no effect on the running walk or on later behaviour.
- R9: pg_ready is high only while busy and waiting for the next page. Exactly as many addresses as the page count are consumed, one per cycle in which pg_valid and pg_ready are both high. Page addresses are 4 KiB aligned.
- R10: The memory port performs at most one access per cycle. Read data is taken one cycle after mem_rd. A rewritten page costs exactly 1024 accesses. A save walk and an unchanged page perform none.
- R11: After reset, busy, done, pg_ready, mem_rd, mem_wr and all dirty bits are low, and no bitmap is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_fixup | input | 1 | 0 = save walk, 1 = fixup walk |
| cmd_bytes | input | BYTES_W (17) | Buffer size in bytes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| pg_valid | input | 1 | Page address valid |
| pg_addr | input | ADDR_W (32) | Physical address of the next page |
| pg_ready | output | 1 | Engine accepts a page address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W (32) | Beat byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after mem_rd |
| dirty | output | MAX_PAGES (16) | Per-page rewritten flags |

## Verification
The bench targets pages whose bit 17 matches in some positions and not in others. A design that swaps on equality, or that ignores the stored bit, changes the wrong pages and raises the wrong dirty bits. The contents of each page are compared word for word against the pattern with its half-select bit toggled. This catches an engine that loses a buffered half, swaps only part of a page, or stops one block early. A fixup with no saved map, a zero-size command, a command sent mid-walk and an oversized size are also driven. A faulty design would there start a walk, consume extra addresses, or miss the done pulse.

// File: rtl/pg17_pkg.sv
package pg17_pkg;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_FETCH,
    WK_SWAP
  } walk_state_t;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_LOAD,
    SW_MOVE,
    SW_STORE
  } swap_phase_t;

  // Pages covered by a byte size, rounded down and limited to max_pages.
  function automatic int unsigned page_count(input int unsigned nbytes,
                                             input int unsigned page_shift,
                                             input int unsigned max_pages);
    int unsigned n;
    n = nbytes >> page_shift;
    if (n > max_pages) n = max_pages;
    return n;
  endfunction

endpackage

// File: rtl/pg17_bitmap.sv
module pg17_bitmap #(
  parameter int MAX_PAGES = 16,
  localparam int IDX_W = $clog2(MAX_PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             commit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  output logic             present
);

  logic [MAX_PAGES-1:0] cell_q;
  logic                 present_q;

  for (genvar g = 0; g < MAX_PAGES; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g))) cell_q[g] <= wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= 1'b0;
    else if (commit) present_q <= 1'b1;
  end

  assign rd_bit  = cell_q[rd_idx];
  assign present = present_q;

  // R1: once a save walk completed, the map stays present
  a_r1_present_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    present_q |=> present_q);

endmodule

// File: rtl/pg17_swap.sv
module pg17_swap
  import pg17_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int DATA_W      = 64,
  parameter int BLOCK_BYTES = 128,
  localparam int FRAME_W    = ADDR_W - PAGE_SHIFT,
  localparam int BEAT_SH    = $clog2(DATA_W / 8),
  localparam int HALF_BEATS = BLOCK_BYTES / 2 / (DATA_W / 8),
  localparam int BEAT_W     = $clog2(HALF_BEATS),
  localparam int BLK_W      = PAGE_SHIFT - $clog2(BLOCK_BYTES),
  localparam int BLOCKS     = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               fin,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);

  swap_phase_t        phase_q;
  logic               sub_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [BLK_W-1:0]   blk_q;
  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0]  hold_q [HALF_BEATS];

  logic beat_last, blk_last, half_sel, capture;

  assign beat_last = (beat_q == BEAT_W'(HALF_BEATS - 1));
  assign blk_last  = (blk_q == BLK_W'(BLOCKS - 1));

  // Load: read low half into hold regs. Move: read high beat, write it low.
  // Store: write held low beats into the high half.
  assign mem_rd   = ((phase_q == SW_LOAD) || (phase_q == SW_MOVE)) && !sub_q;
  assign mem_wr   = ((phase_q == SW_MOVE) && sub_q) || (phase_q == SW_STORE);
  assign half_sel = ((phase_q == SW_MOVE) && !sub_q) || (phase_q == SW_STORE);
  assign capture  = (phase_q == SW_LOAD) && sub_q;
  assign mem_addr = {frame_q, blk_q, half_sel, beat_q, {BEAT_SH{1'b0}}};
  assign mem_wdata = (phase_q == SW_STORE) ? hold_q[beat_q] : mem_rdata;
  assign fin      = (phase_q == SW_STORE) && beat_last && blk_last;

  always_ff @(posedge clk) begin
    if (capture) hold_q[beat_q] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SW_IDLE;
      sub_q   <= 1'b0;
      beat_q  <= '0;
      blk_q   <= '0;
      frame_q <= '0;
    end else begin
      unique case (phase_q)
        SW_IDLE: if (start) begin
          phase_q <= SW_LOAD;
          frame_q <= frame;
          sub_q   <= 1'b0;
          beat_q  <= '0;
          blk_q   <= '0;
        end
        SW_LOAD, SW_MOVE: begin
          sub_q <= !sub_q;
          if (sub_q) begin
            if (beat_last) begin
              beat_q  <= '0;
              phase_q <= (phase_q == SW_LOAD) ? SW_MOVE : SW_STORE;
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
            end
          end
        end
        SW_STORE: begin
          if (beat_last) begin
            beat_q <= '0;
            if (blk_last) phase_q <= SW_IDLE;
            else begin
              blk_q   <= blk_q + BLK_W'(1);
              phase_q <= SW_LOAD;
            end
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        default: phase_q <= SW_IDLE;
      endcase
    end
  end

  // R10: one access per cycle on the memory port
  a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R4: a new page rewrite only starts when the previous one is over
  a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase_q == SW_IDLE));

  // R10: read data is consumed exactly one cycle after its read
  a_r10_capture_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (capture || mem_wr));

endmodule

// File: rtl/pg17_walker.sv
module pg17_walker
  import pg17_pkg::*;
#(
  parameter int MAX_PAGES  = 16,
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PARITY_BIT = 17,
  localparam int IDX_W     = $clog2(MAX_PAGES),
  localparam int CNT_W     = IDX_W + 1,
  localparam int FRAME_W   = ADDR_W - PAGE_SHIFT,
  localparam int BYTES_W   = PAGE_SHIFT + CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_fixup,
  input  logic [BYTES_W-1:0] cmd_bytes,
  output logic               busy,
  output logic               done,
  input  logic               pg_valid,
  input  logic [FRAME_W-1:0] pg_frame,
  output logic               pg_ready,
  output logic               map_wr,
  output logic [IDX_W-1:0]   map_idx,
  output logic               map_bit,
  output logic               map_commit,
  input  logic               map_rd_bit,
  input  logic               map_present,
  output logic               swap_start,
  output logic [FRAME_W-1:0] swap_frame,
  input  logic               swap_fin,
  output logic [MAX_PAGES-1:0] dirty
);

  walk_state_t          state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [CNT_W-1:0]     npages_q;
  logic                 fixup_q;
  logic                 done_q;
  logic [MAX_PAGES-1:0] dirty_q;

  logic [CNT_W-1:0] cmd_pages;
  logic accept, hs, flip, page_end, last_page;

  assign cmd_pages = CNT_W'(page_count(32'(cmd_bytes), PAGE_SHIFT, MAX_PAGES));
  assign accept    = cmd_valid && (state_q == WK_IDLE) && (cmd_pages != '0) &&
                     (!cmd_fixup || map_present);
  assign pg_ready  = (state_q == WK_FETCH);
  assign hs        = pg_valid && pg_ready;
  assign flip      = pg_frame[PARITY_BIT - PAGE_SHIFT] ^ map_rd_bit;
  assign last_page = (CNT_W'({1'b0, idx_q}) + CNT_W'(1)) == npages_q;

  assign swap_start = hs && fixup_q && flip;
  assign swap_frame = pg_frame;
  assign page_end   = (hs && !(fixup_q && flip)) ||
                      ((state_q == WK_SWAP) && swap_fin);

  assign map_wr     = hs && !fixup_q;
  assign map_idx    = idx_q;
  assign map_bit    = pg_frame[PARITY_BIT - PAGE_SHIFT];
  assign map_commit = page_end && last_page && !fixup_q;

  assign busy  = (state_q != WK_IDLE);
  assign done  = done_q;
  assign dirty = dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WK_IDLE;
      idx_q    <= '0;
      npages_q <= '0;
      fixup_q  <= 1'b0;
      done_q   <= 1'b0;
      dirty_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == WK_IDLE) begin
        if (accept) begin
          state_q  <= WK_FETCH;
          idx_q    <= '0;
          npages_q <= cmd_pages;
          fixup_q  <= cmd_fixup;
          dirty_q  <= '0;
        end
      end else begin
        if (swap_start) state_q <= WK_SWAP;
        if ((state_q == WK_SWAP) && swap_fin) dirty_q[idx_q] <= 1'b1;
        if (page_end) begin
          if (last_page) begin
            state_q <= WK_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= WK_FETCH;
            idx_q   <= idx_q + IDX_W'(1);
          end
        end
      end
    end
  end

  // R9: addresses are only taken during a walk
  a_r9_ready_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ready |-> busy);

  // R7: done lasts a single cycle and is never seen together with busy
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: fixup with no saved map does not start a walk
  a_r6_no_map_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_fixup && !map_present && !busy) |=> !busy);

  // R8: a command during a walk leaves the walk setup untouched
  a_r8_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(npages_q) && $stable(fixup_q)));

  // R5: dirty flags do not move during a save walk
  a_r5_save_keeps_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fixup_q) |=> $stable(dirty_q));

endmodule

// File: rtl/pg17_fixup_engine.sv
module pg17_fixup_engine #(
  parameter int MAX_PAGES   = 16,
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int DATA_W      = 64,
  parameter int BLOCK_BYTES = 128,
  parameter int PARITY_BIT  = 17,
  localparam int IDX_W      = $clog2(MAX_PAGES),
  localparam int CNT_W      = IDX_W + 1,
  localparam int FRAME_W    = ADDR_W - PAGE_SHIFT,
  localparam int BYTES_W    = PAGE_SHIFT + CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_fixup,
  input  logic [BYTES_W-1:0]   cmd_bytes,
  output logic                 busy,
  output logic                 done,
  input  logic                 pg_valid,
  input  logic [ADDR_W-1:0]    pg_addr,
  output logic                 pg_ready,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [MAX_PAGES-1:0] dirty
);

  logic             map_wr, map_bit, map_commit, map_rd_bit, map_present;
  logic [IDX_W-1:0] map_idx;
  logic             swap_start, swap_fin;
  logic [FRAME_W-1:0] swap_frame;

  pg17_bitmap #(.MAX_PAGES(MAX_PAGES)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr),
    .wr_idx  (map_idx),
    .wr_bit  (map_bit),
    .commit  (map_commit),
    .rd_idx  (map_idx),
    .rd_bit  (map_rd_bit),
    .present (map_present)
  );

  pg17_walker #(
    .MAX_PAGES (MAX_PAGES),
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .PARITY_BIT(PARITY_BIT)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_fixup  (cmd_fixup),
    .cmd_bytes  (cmd_bytes),
    .busy       (busy),
    .done       (done),
    .pg_valid   (pg_valid),
    .pg_frame   (pg_addr[ADDR_W-1:PAGE_SHIFT]),
    .pg_ready   (pg_ready),
    .map_wr     (map_wr),
    .map_idx    (map_idx),
    .map_bit    (map_bit),
    .map_commit (map_commit),
    .map_rd_bit (map_rd_bit),
    .map_present(map_present),
    .swap_start (swap_start),
    .swap_frame (swap_frame),
    .swap_fin   (swap_fin),
    .dirty      (dirty)
  );

  pg17_swap #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .DATA_W     (DATA_W),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_swap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (swap_start),
    .frame    (swap_frame),
    .fin      (swap_fin),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // R9: page addresses handed over are page aligned
  a_r9_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && pg_ready) |-> (pg_addr[PAGE_SHIFT-1:0] == '0));

  // R10: no memory traffic outside a walk
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr));

endmodule

// File: tb/tb_pg17_fixup_engine.sv
module tb_pg17_fixup_engine;

  localparam int MAXP = 16;
  localparam int WORDS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_fixup = 1'b0;
  logic [16:0] cmd_bytes = '0;
  logic        busy, done, pg_ready;
  logic        pg_valid = 1'b0;
  logic [31:0] pg_addr = '0;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic [MAXP-1:0] dirty;

  int checks = 0;
  int fails = 0;
  int accesses = 0;
  logic [63:0] mem [4*WORDS];

  always #5 clk = ~clk;

  pg17_fixup_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_fixup(cmd_fixup),
    .cmd_bytes(cmd_bytes), .busy(busy), .done(done), .pg_valid(pg_valid),
    .pg_addr(pg_addr), .pg_ready(pg_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dirty(dirty)
  );

  function automatic int widx(input logic [31:0] a);
    return int'({a[13:12], a[11:3]});
  endfunction

  function automatic logic [63:0] pattern(input int slot, input int w);
    return {8'hC0 + 8'(slot), 8'h5A, 16'(w), 16'hBEEF, 16'(w * 7 + slot)};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[widx(mem_addr)];
    if (mem_wr) mem[widx(mem_addr)] <= mem_wdata;
    if (mem_rd || mem_wr) accesses <= accesses + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < WORDS; w++) mem[s*WORDS + w] = pattern(s, w);
  endtask

  // Page i lives in memory slot i; bit 17 of its address comes from the mask.
  function automatic logic [31:0] page_addr(input int i, input logic [15:0] m);
    return 32'h0040_0000 | (32'(m[i]) << 17) | (32'(i % 4) << 12);
  endfunction

  task automatic issue(input bit fix, input int nbytes);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_fixup = fix; cmd_bytes = 17'(nbytes);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic feed(input int n, input logic [15:0] m, output bit done_now,
                      output bit saw_done);
    int k;
    done_now = 1'b0;
    for (int i = 0; i < n; i++) begin
      pg_valid = 1'b1; pg_addr = page_addr(i, m);
      k = 0;
      while (!pg_ready && k < 3000) begin @(negedge clk); k++; end
      @(negedge clk);
    end
    pg_valid = 1'b0;
    done_now = done && !busy;
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    saw_done = done && !busy;
    @(negedge clk);
  endtask

  task automatic check_page(input int slot, input bit swapped, input string req);
    int bad;
    logic [63:0] exp, act;
    bad = 0; exp = '0; act = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (mem[slot*WORDS + w] !== pattern(slot, swapped ? (w ^ 8) : w) && bad == 0) begin
        bad = 1; act = mem[slot*WORDS + w];
        exp = pattern(slot, swapped ? (w ^ 8) : w);
      end
    end
    chk(bad == 0, req, $sformatf("page %0d contents", slot), act, exp);
  endtask

  // {pages, save bit-17 mask, fixup bit-17 mask}
  localparam logic [11:0] VEC [4] = '{
    {4'd4, 4'b0000, 4'b1010},
    {4'd3, 4'b1111, 4'b1110},
    {4'd4, 4'b0101, 4'b0101},
    {4'd2, 4'b0011, 4'b1100}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit dn, sd;
    int n, nflip;
    logic [3:0] sm, fm, diff, live;
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(!busy && !done && !pg_ready, "R11", "busy/done/ready after reset",
        {busy, done, pg_ready}, 0);
    chk(!mem_rd && !mem_wr && dirty == '0, "R11", "mem strobes and dirty",
        {mem_rd, mem_wr, dirty}, 0);

    // R6 fixup before any save
    issue(1'b1, 4*4096);
    sd = 1'b0;
    for (int c = 0; c < 6; c++) begin
      if (busy || pg_ready || done) sd = 1'b1;
      @(negedge clk);
    end
    chk(!sd, "R6", "fixup without map started a walk", sd, 0);

    // R2 zero-page command ignored
    issue(1'b0, 100);
    chk(!busy && !pg_ready, "R2", "zero-size command", {busy, pg_ready}, 0);

    // Table of save/fixup vectors
    for (int v = 0; v < 4; v++) begin
      n = int'(VEC[v][11:8]); sm = VEC[v][7:4]; fm = VEC[v][3:0];
      fill_mem();
      accesses = 0;
      issue(1'b0, n * 4096 + 5);
      feed(n, 16'(sm), dn, sd);
      chk(dn, "R7", $sformatf("vec %0d save done right after last page", v), dn, 1);
      chk(accesses == 0, "R10", "no memory access in save walk", accesses, 0);
      live = 4'((1 << n) - 1);
      diff = (sm ^ fm) & live;
      nflip = $countones(diff);
      accesses = 0;
      issue(1'b1, n * 4096);
      feed(n, 16'(fm), dn, sd);
      chk(sd, "R7", $sformatf("vec %0d fixup done pulse", v), sd, 1);
      chk(accesses == 1024 * nflip, "R10", "access count of fixup",
          accesses, 1024 * nflip);
      chk(dirty == MAXP'(diff), "R5", $sformatf("vec %0d dirty flags", v),
          dirty, diff);
      for (int p = 0; p < 4; p++) check_page(p, diff[p], "R3 R4");
    end

    // R1/R3: second fixup without a new save swaps the flipped pages back
    fill_mem();
    issue(1'b0, 2 * 4096);
    feed(2, 16'b00, dn, sd);
    issue(1'b1, 2 * 4096);
    feed(2, 16'b10, dn, sd);
    issue(1'b1, 2 * 4096);
    feed(2, 16'b10, dn, sd);
    check_page(1, 1'b0, "R1");
    chk(dirty == MAXP'(2), "R5", "dirty after repeat fixup", dirty, 2);

    // R8 command while busy ignored
    issue(1'b0, 2 * 4096);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_fixup = 1'b1; cmd_bytes = 17'(4 * 4096);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(dirty == '0, "R5", "dirty cleared on accept", dirty, 0);
    feed(2, 16'b11, dn, sd);
    chk(dn, "R8", "walk ends after original page count", dn, 1);
    repeat (4) @(negedge clk);
    chk(!busy && !pg_ready, "R9", "no further addresses taken", {busy, pg_ready}, 0);

    // R2 clamp to MAX_PAGES
    issue(1'b0, 20 * 4096);
    feed(MAXP, 16'hA5A5, dn, sd);
    chk(dn, "R2", "oversize walk ends after MAX_PAGES pages", dn, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule